// File: doc/BRIEF.md
# LPC Interrupt Status and Routing Unit

This unit gathers interrupt requests from devices on a low pin count bus, together with a set of internal error events, into a latched status register. A mask register selects which of those status bits take part. It receives per-IRQ levels that have already been decoded from the serial interrupt frame. It does not decode the frame on the wire.

When routed mode is selected by the `routed_en` pin, each device interrupt is steered by a 2-bit field onto one of four unlatched serial-IRQ output lines. In routed mode the device interrupts are then removed from the rest of the path. Every source that remains active is reduced to a single flag. That flag feeds a second, sticky, masked latch on the bus master side, and that latch drives one host interrupt line.

The block has a 32-bit register port. A single-cycle write strobe updates registers. Reads are combinational. A select pin picks between the host-controller register bank and the master register bank.

Top module: `lpc_irq_router`

## Requirements
- R1: After reset every stored register reads 0, `serirq_out` is 0 and `host_irq` is low.
- R2: Device input `dev_irq[n]` corresponds to host-controller status bit 31-n (IRQ0 is bit 31, IRQ15 is bit 16). While the input is high, the status bit is set, and this is visible in the cycle after the input is sampled.
- R3: Writing the host-controller status register (offset 0x38) clears each written-1 bit only if the matching device input is low. Event pulses on `evt_set[10]` and `evt_set[7:0]` set the same-numbered status bits; bit 6 is the bus no-response error. Event bits 9 and 8 are ignored. Written 1s clear event bits.
- R4: The active set is status AND mask (mask register at 0x34). When bit 31 of the control register (0x30) is 0, bits 31:15 are dropped from the active set.
- R5: In routed mode with control bit 23 set, a device input going low clears its status bit at the next clock edge.
- R6: In routed mode, IRQ k for k from 0 to 13 uses bits [27-2k:26-2k] of route register 1 (0x0C). IRQ 14 and IRQ 15 use bits [23:22] and [21:20] of route register 0 (0x08). The field value selects output line 0 to 3.
- R7: Each `serirq_out` line is the OR of the active device IRQs routed to it. All lines are 0 when not in routed mode. In routed mode, device IRQs do not reach the master path.
- R8: Bit 11 of the master input register (0x5C) shows whether any remaining active source exists. The master status register (0x50) ORs in (input AND master mask at 0x54), keeps its bits until they are cleared by writing 1s, and `host_irq` is high while it is nonzero.
- R9: Offsets 0x30, 0x34, 0x38 and 0x40 are in the host-controller bank; 0x08, 0x0C, 0x50, 0x54, 0x58 and 0x5C are in the master bank. Any other offset reads all ones. The input register ignores writes. Offset 0x40 reads 0 and ignores writes. The polarity register (0x58) is stored but has no effect.
- R10: Writes to either route register are ignored while `routed_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| routed_en | input | 1 | Selects routed mode with four serial-IRQ lines |
| dev_irq | input | 16 | Decoded device interrupt levels, IRQ0 to IRQ15 |
| evt_set | input | 11 | Internal event pulses, one per status bit 10:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_hc_sel | input | 1 | 1 selects the host-controller bank, 0 selects the master bank |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| serirq_out | output | 4 | Routed serial-IRQ output lines |
| host_irq | output | 1 | Host interrupt, high while master status is nonzero |

## Verification
The hardest case to reach is a write-1 clear racing a device input that is still asserted. The stimulus for it holds the input high and writes the clear. It then reads back the status bit, drops the input, and finally checks that the same write now succeeds. A second hard case is a master status bit that must outlive its cause. Here an event pulse raises the host line, the host-controller bit is cleared, and the bench confirms that the master bit and `host_irq` stay set until the master register is written.

// File: rtl/lpc_irq_pkg.sv
package lpc_irq_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_DEV   = 16;
    localparam int NUM_LINES = 4;
    localparam int ROUTE_W   = $clog2(NUM_LINES);
    localparam int EVT_W     = 11;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] OFS_M_ROUTE0 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_M_ROUTE1 = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_M_STAT   = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_M_MASK   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_M_POL    = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_M_INPUT  = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_H_CTRL   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_H_MASK   = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_H_STAT   = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_H_ERRA   = 8'h40;

    localparam logic [REG_W-1:0] DEV_FIELD = 32'hFFFF_8000;
    localparam logic [REG_W-1:0] EVT_FIELD = 32'h0000_04FF;
    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_AUTO_BIT = 23;
    localparam int M_SRC_BIT     = 11;
    localparam int R1_TOP        = 27;
    localparam int R0_TOP        = 23;
    localparam int R1_COUNT      = 14;

    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] stat;
    } hc_state_t;

    typedef struct packed {
        logic [REG_W-1:0] route0;
        logic [REG_W-1:0] route1;
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] mask;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] inp;
    } mst_state_t;
endpackage

// File: rtl/lpc_irq_hc_stat.sv
module lpc_irq_hc_stat
    import lpc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               routed_en,
    input  logic [NUM_DEV-1:0] dev_irq,
    input  logic [EVT_W-1:0]   evt_set,
    input  logic               wr_ctrl,
    input  logic               wr_mask,
    input  logic               wr_stat,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   ctrl_q,
    output logic [REG_W-1:0]   mask_q,
    output logic [REG_W-1:0]   stat_q,
    output logic [REG_W-1:0]   active_q,
    output logic               rest_any_d
);
    hc_state_t s_d, s_q;
    logic [REG_W-1:0] lvl, clr, auto_clr, evt_bits, act_d, rest_d;

    always_comb begin
        lvl = '0;
        for (int k = 0; k < NUM_DEV; k++) begin
            lvl[REG_W-1-k] = dev_irq[k];
        end
        evt_bits = {{(REG_W-EVT_W){1'b0}}, evt_set} & EVT_FIELD;

        s_d = s_q;
        if (wr_ctrl) s_d.ctrl = wdata;
        if (wr_mask) s_d.mask = wdata;

        clr      = wr_stat ? (wdata & ~lvl) : '0;
        auto_clr = (routed_en && s_d.ctrl[CTRL_AUTO_BIT]) ? (DEV_FIELD & ~lvl) : '0;
        s_d.stat = (s_q.stat & ~clr & ~auto_clr) | lvl | evt_bits;

        act_d  = s_d.stat & s_d.mask & (s_d.ctrl[CTRL_EN_BIT] ? '1 : ~DEV_FIELD);
        rest_d = routed_en ? (act_d & ~DEV_FIELD) : act_d;
        rest_any_d = |rest_d;

        active_q = s_q.stat & s_q.mask & (s_q.ctrl[CTRL_EN_BIT] ? '1 : ~DEV_FIELD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_q = s_q.ctrl;
    assign mask_q = s_q.mask;
    assign stat_q = s_q.stat;

    // R2: an asserted device level is latched by the next cycle
    a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.stat & $past(lvl)) == $past(lvl)));

    // R3: an event pulse leaves its status bit set
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.stat & $past(evt_bits)) == $past(evt_bits)));
endmodule

// File: rtl/lpc_irq_route.sv
module lpc_irq_route
    import lpc_irq_pkg::*;
(
    input  logic                 routed_en,
    input  logic [REG_W-1:0]     active,
    input  logic [REG_W-1:0]     route0,
    input  logic [REG_W-1:0]     route1,
    output logic [NUM_LINES-1:0] lines
);
    logic [ROUTE_W-1:0] sel [NUM_DEV];

    for (genvar k = 0; k < NUM_DEV; k++) begin : g_field
        if (k < R1_COUNT) begin : g_r1
            assign sel[k] = route1[R1_TOP-2*k -: ROUTE_W];
        end else begin : g_r0
            assign sel[k] = route0[R0_TOP-2*(k-R1_COUNT) -: ROUTE_W];
        end
    end

    always_comb begin
        lines = '0;
        if (routed_en) begin
            for (int k = 0; k < NUM_DEV; k++) begin
                if (active[REG_W-1-k]) lines[sel[k]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpc_irq_master.sv
module lpc_irq_master
    import lpc_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             routed_en,
    input  logic             wr_route0,
    input  logic             wr_route1,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic             wr_pol,
    input  logic [REG_W-1:0] wdata,
    input  logic             any_d,
    output logic [REG_W-1:0] route0_q,
    output logic [REG_W-1:0] route1_q,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] mask_q,
    output logic [REG_W-1:0] pol_q,
    output logic [REG_W-1:0] inp_q,
    output logic             host_irq
);
    mst_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_route0 && routed_en) s_d.route0 = wdata;
        if (wr_route1 && routed_en) s_d.route1 = wdata;
        if (wr_mask) s_d.mask = wdata;
        if (wr_pol)  s_d.pol  = wdata;
        s_d.inp = '0;
        s_d.inp[M_SRC_BIT] = any_d;
        s_d.stat = (s_q.stat & ~(wr_stat ? wdata : '0)) | (s_d.inp & s_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign route0_q = s_q.route0;
    assign route1_q = s_q.route1;
    assign stat_q   = s_q.stat;
    assign mask_q   = s_q.mask;
    assign pol_q    = s_q.pol;
    assign inp_q    = s_q.inp;
    assign host_irq = |s_q.stat;

    // R8: master status bits are sticky without a status write
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((s_q.stat & $past(s_q.stat)) == $past(s_q.stat)));

    // R10: route registers hold while routed mode is off
    a_r10_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !routed_en |=> (s_q.route0 == $past(s_q.route0) && s_q.route1 == $past(s_q.route1)));
endmodule

// File: rtl/lpc_irq_router.sv
module lpc_irq_router
    import lpc_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 routed_en,
    input  logic [NUM_DEV-1:0]   dev_irq,
    input  logic [EVT_W-1:0]     evt_set,
    input  logic                 reg_wr,
    input  logic                 reg_hc_sel,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] serirq_out,
    output logic                 host_irq
);
    logic wr_h, wr_m;
    logic [REG_W-1:0] h_ctrl, h_mask, h_stat, h_act;
    logic [REG_W-1:0] m_r0, m_r1, m_stat, m_mask, m_pol, m_inp;
    logic rest_any;

    assign wr_h = reg_wr &&  reg_hc_sel;
    assign wr_m = reg_wr && !reg_hc_sel;

    lpc_irq_hc_stat u_hc (
        .clk        (clk),
        .rst_n      (rst_n),
        .routed_en  (routed_en),
        .dev_irq    (dev_irq),
        .evt_set    (evt_set),
        .wr_ctrl    (wr_h && reg_addr == OFS_H_CTRL),
        .wr_mask    (wr_h && reg_addr == OFS_H_MASK),
        .wr_stat    (wr_h && reg_addr == OFS_H_STAT),
        .wdata      (reg_wdata),
        .ctrl_q     (h_ctrl),
        .mask_q     (h_mask),
        .stat_q     (h_stat),
        .active_q   (h_act),
        .rest_any_d (rest_any)
    );

    lpc_irq_route u_route (
        .routed_en (routed_en),
        .active    (h_act),
        .route0    (m_r0),
        .route1    (m_r1),
        .lines     (serirq_out)
    );

    lpc_irq_master u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .routed_en (routed_en),
        .wr_route0 (wr_m && reg_addr == OFS_M_ROUTE0),
        .wr_route1 (wr_m && reg_addr == OFS_M_ROUTE1),
        .wr_stat   (wr_m && reg_addr == OFS_M_STAT),
        .wr_mask   (wr_m && reg_addr == OFS_M_MASK),
        .wr_pol    (wr_m && reg_addr == OFS_M_POL),
        .wdata     (reg_wdata),
        .any_d     (rest_any),
        .route0_q  (m_r0),
        .route1_q  (m_r1),
        .stat_q    (m_stat),
        .mask_q    (m_mask),
        .pol_q     (m_pol),
        .inp_q     (m_inp),
        .host_irq  (host_irq)
    );

    always_comb begin
        reg_rdata = '1;
        if (reg_hc_sel) begin
            case (reg_addr)
                OFS_H_CTRL: reg_rdata = h_ctrl;
                OFS_H_MASK: reg_rdata = h_mask;
                OFS_H_STAT: reg_rdata = h_stat;
                OFS_H_ERRA: reg_rdata = '0;
                default:    reg_rdata = '1;
            endcase
        end else begin
            case (reg_addr)
                OFS_M_ROUTE0: reg_rdata = m_r0;
                OFS_M_ROUTE1: reg_rdata = m_r1;
                OFS_M_STAT:   reg_rdata = m_stat;
                OFS_M_MASK:   reg_rdata = m_mask;
                OFS_M_POL:    reg_rdata = m_pol;
                OFS_M_INPUT:  reg_rdata = m_inp;
                default:      reg_rdata = '1;
            endcase
        end
    end

    // R4: with the serial enable clear no device IRQ reaches a routed line
    a_r4_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !h_ctrl[CTRL_EN_BIT] |-> (serirq_out == '0));

    // R7: routed lines stay quiet outside routed mode
    a_r7_unrouted_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !routed_en |-> (serirq_out == '0));
endmodule

// File: tb/lpc_irq_router_tb.sv
module lpc_irq_router_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NTBL = 11;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        routed_en = 0;
    logic [15:0] dev_irq = '0;
    logic [10:0] evt_set = '0;
    logic        reg_wr = 0;
    logic        reg_hc_sel = 0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  serirq_out;
    logic        host_irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpc_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .routed_en(routed_en), .dev_irq(dev_irq),
        .evt_set(evt_set), .reg_wr(reg_wr), .reg_hc_sel(reg_hc_sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .serirq_out(serirq_out), .host_irq(host_irq)
    );

    // {hc_sel, offset, write data, expected readback}; R9 register map
    localparam logic [72:0] TBL [NTBL] = '{
        {1'b1, 8'h30, 32'h8080_0000, 32'h8080_0000},
        {1'b1, 8'h34, 32'hFFFF_84FF, 32'hFFFF_84FF},
        {1'b1, 8'h40, 32'h1234_5678, 32'h0000_0000},
        {1'b1, 8'h44, 32'h0000_0000, 32'hFFFF_FFFF},
        {1'b0, 8'h08, 32'h0040_0000, 32'h0040_0000},
        {1'b0, 8'h0C, 32'h0020_0000, 32'h0020_0000},
        {1'b0, 8'h54, 32'h0000_0800, 32'h0000_0800},
        {1'b0, 8'h58, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        {1'b0, 8'h5C, 32'hFFFF_FFFF, 32'h0000_0000},
        {1'b0, 8'h10, 32'h0000_0000, 32'hFFFF_FFFF},
        {1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_hc_sel = s; reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic s, input logic [7:0] a, output logic [31:0] d);
        reg_hc_sel = s; reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog got=%h exp=%h", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        rd(1, 8'h38, v); chk("R1 hc stat", v, 0);
        rd(1, 8'h30, v); chk("R1 ctrl", v, 0);
        rd(0, 8'h50, v); chk("R1 m stat", v, 0);
        rd(0, 8'h0C, v); chk("R1 route1", v, 0);
        chk("R1 lines", {28'b0, serirq_out}, 0);
        chk("R1 host", {31'b0, host_irq}, 0);

        routed_en = 1;
        for (int i = 0; i < NTBL; i++) begin
            wr(TBL[i][72], TBL[i][71:64], TBL[i][63:32]);
            rd(TBL[i][72], TBL[i][71:64], v);
            chk("R9 table", v, TBL[i][31:0]);
        end
        chk("R9 polarity no effect", {31'b0, host_irq}, 0);

        // R2 R6 R7: IRQ3 -> line 2 via route1 [21:20]
        wr(1, 8'h30, 32'h8000_0000);
        dev_irq[3] = 1; step();
        rd(1, 8'h38, v); chk("R2 irq3 bit28", v, 32'h1000_0000);
        chk("R6 irq3 line2", {28'b0, serirq_out}, 32'h4);
        chk("R7 routed excludes device", {31'b0, host_irq}, 0);
        // R3 clear refused while input high
        wr(1, 8'h38, 32'h1000_0000);
        rd(1, 8'h38, v); chk("R3 protected clear", v, 32'h1000_0000);
        dev_irq[3] = 0; step();
        rd(1, 8'h38, v); chk("R3 held without autoclear", v, 32'h1000_0000);
        wr(1, 8'h38, 32'h1000_0000);
        rd(1, 8'h38, v); chk("R3 clear after deassert", v, 0);
        chk("R7 line drops", {28'b0, serirq_out}, 0);

        // R5 R6: IRQ14 -> line 1 via route0 [23:22], auto-clear
        wr(1, 8'h30, 32'h8080_0000);
        dev_irq[14] = 1; step();
        chk("R6 irq14 line1", {28'b0, serirq_out}, 32'h2);
        dev_irq[14] = 0; step();
        rd(1, 8'h38, v); chk("R5 autoclear", v, 0);
        chk("R5 line off", {28'b0, serirq_out}, 0);

        // R4 enable off gates device bits
        wr(1, 8'h30, 32'h0);
        dev_irq[3] = 1; step();
        rd(1, 8'h38, v); chk("R4 status still latched", v, 32'h1000_0000);
        chk("R4 gated line", {28'b0, serirq_out}, 0);
        dev_irq[3] = 0; wr(1, 8'h38, 32'hFFFF_FFFF);

        // R8 event no-response -> master path
        @(negedge clk); evt_set = 11'h340; step(); evt_set = '0;
        rd(1, 8'h38, v); chk("R3 event bit6 only", v, 32'h40);
        rd(0, 8'h5C, v); chk("R8 input bit11", v, 32'h800);
        rd(0, 8'h50, v); chk("R8 m stat", v, 32'h800);
        chk("R8 host high", {31'b0, host_irq}, 1);
        wr(1, 8'h38, 32'h40);
        rd(0, 8'h5C, v); chk("R8 input drops", v, 0);
        chk("R8 sticky host", {31'b0, host_irq}, 1);
        wr(0, 8'h50, 32'h800);
        chk("R8 host cleared", {31'b0, host_irq}, 0);

        // R10 non-routed mode
        routed_en = 0;
        wr(0, 8'h0C, 32'hFFFF_FFFF);
        rd(0, 8'h0C, v); chk("R10 route1 held", v, 32'h0020_0000);
        dev_irq[5] = 1; step();
        rd(0, 8'h5C, v); chk("R4 disabled device", v, 0);
        wr(1, 8'h30, 32'h8000_0000);
        chk("R7 no lines unrouted", {28'b0, serirq_out}, 0);
        rd(0, 8'h5C, v); chk("R7 device reaches master", v, 32'h800);
        chk("R8 host from device", {31'b0, host_irq}, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule